// File: doc/BRIEF.md
# Interrupt Status and Mask Register Bank

This block is the 32-bit memory-mapped register bank that sits beside an on-chip RAM controller and gathers its interrupt sources. Eleven hardware event lines each set a sticky bit in a status register; software acknowledges a bit by writing a one to it. A mask register decides which pending bits reach the single level-sensitive interrupt output. Software never writes the mask directly. It writes a one-hot or multi-bit pattern to a write-only enable port to unmask bits, or to a write-only disable port to mask them.

The bank also holds a small error-control register and a read-only implementation register that reports the RAM size chosen at elaboration as a compact code. It has a read-only debug readiness word and two read-only fault address words that are fed from outside the block. The RAM array, its ECC logic and the fault capture paths live elsewhere.

Top module: `irq_bank_top`

## Requirements
- R1: After reset the status register reads 0, the mask reads 0x7FF (all eleven sources masked), error control reads 0xF, and `irqOut` is low.
- R2: A high bit on `eventIn` during a clock edge sets the matching status bit (status at byte offset 0x04, bit n for source n). Status bits never set without an event.
- R3: A full-word write to status clears every bit written as 1 and leaves the others. Status bits 31:11 always read as zero.
- R4: When an event and a write-one-to-clear hit the same status bit on the same edge, the bit ends up set.
- R5: A write to the enable port (offset 0x0C) clears each mask bit (mask at offset 0x08) whose data bit is 1 and leaves the rest.
- R6: A write to the disable port (offset 0x10) sets each mask bit whose data bit is 1 and leaves the rest.
- R7: The enable and disable ports read as zero. A write to the mask offset has no effect on the mask.
- R8: `irqOut` is high exactly when some status bit is set while its mask bit is clear. It follows every status, enable or disable write from the next cycle.
- R9: Error control (offset 0x00) stores bits 3:0 of a write. Bits 31:4 read as zero.
- R10: The implementation word (offset 0x1C) reads the RAM size code in bits 3:0: 64 KiB→0, 128 KiB→1, 256 KiB→2, 512 KiB→3, 1 MiB→4. Writes are ignored, and any other size fails elaboration.
- R11: The debug readiness word (offset 0x20) reads 0xFFFF and ignores writes.
- R12: An access whose address is not word aligned or whose byte enables are not all four set has no effect, and a read of that kind returns zero.
- R13: The correctable and uncorrectable fault address inputs read back zero-extended at offsets 0x14 and 0x18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrite | input | 1 | Write request this cycle |
| busRead | input | 1 | Read request this cycle |
| busAddr | input | ADDR_W | Byte address |
| busByteEn | input | 4 | Byte lane enables; only 4'hF is accepted |
| busWdata | input | 32 | Write data |
| eventIn | input | 11 | Hardware interrupt event pulses |
| ceFaultAddr | input | 20 | Captured correctable-fault address |
| ueFaultAddr | input | 20 | Captured uncorrectable-fault address |
| busRdata | output | 32 | Read data, combinational on a valid read |
| irqOut | output | 1 | Level interrupt |

## Verification
The hardest case to reach is the collision where a hardware event sets a status bit on the same edge that software's write-one-to-clear removes it. Nothing inside the bank lines the two up, so the outcome depends entirely on the priority in the next-state logic. The bench drives an event pulse and a status write in the same cycle, both in a directed case and in the random phase, where events and clears are drawn for the same cycle. The expected status and interrupt level come from a bench model.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int DATA_W       = 32;
  localparam int IRQ_W        = 11;
  localparam int ERR_W        = 4;
  localparam int READY_W      = 16;
  localparam int FAULT_ADDR_W = 20;
  localparam int CODE_W       = 4;

  // Word indices (byte offset / 4)
  localparam int WIDX_ERRCTL  = 0;
  localparam int WIDX_STATUS  = 1;
  localparam int WIDX_MASK    = 2;
  localparam int WIDX_ENABLE  = 3;
  localparam int WIDX_DISABLE = 4;
  localparam int WIDX_CEADDR  = 5;
  localparam int WIDX_UEADDR  = 6;
  localparam int WIDX_IMPL    = 7;
  localparam int WIDX_READY   = 8;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_ERRCTL, SEL_STATUS, SEL_MASK, SEL_ENABLE,
    SEL_DISABLE, SEL_CEADDR, SEL_UEADDR, SEL_IMPL, SEL_READY
  } rdSel_e;

  typedef struct packed {
    logic   statusClr;
    logic   maskEnable;
    logic   maskDisable;
    logic   errCtlWr;
    rdSel_e rdSel;
  } bankStrobe_t;

  function automatic logic [CODE_W-1:0] sizeToCode(longint unsigned bytes);
    case (bytes)
      64'd65536:   return 4'd0;
      64'd131072:  return 4'd1;
      64'd262144:  return 4'd2;
      64'd524288:  return 4'd3;
      64'd1048576: return 4'd4;
      default:     return 4'hF;
    endcase
  endfunction
endpackage

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
  import irq_bank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrite,
  input  logic              busRead,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [3:0]        busByteEn,
  output bankStrobe_t       strobe
);
  localparam int WORD_W = ADDR_W - 2;

  logic              accessOk;
  logic [WORD_W-1:0] wordIdx;
  logic              doWrite;
  logic              doRead;

  assign accessOk = (busAddr[1:0] == 2'b00) && (busByteEn == 4'hF);
  assign wordIdx  = busAddr[ADDR_W-1:2];
  assign doWrite  = busWrite && accessOk;
  assign doRead   = busRead && accessOk;

  always_comb begin
    strobe = '{statusClr: 1'b0, maskEnable: 1'b0, maskDisable: 1'b0,
               errCtlWr: 1'b0, rdSel: SEL_NONE};
    if (doWrite) begin
      case (int'(wordIdx))
        WIDX_ERRCTL:  strobe.errCtlWr    = 1'b1;
        WIDX_STATUS:  strobe.statusClr   = 1'b1;
        WIDX_ENABLE:  strobe.maskEnable  = 1'b1;
        WIDX_DISABLE: strobe.maskDisable = 1'b1;
        default: ;
      endcase
    end
    if (doRead) begin
      case (int'(wordIdx))
        WIDX_ERRCTL:  strobe.rdSel = SEL_ERRCTL;
        WIDX_STATUS:  strobe.rdSel = SEL_STATUS;
        WIDX_MASK:    strobe.rdSel = SEL_MASK;
        WIDX_ENABLE:  strobe.rdSel = SEL_ENABLE;
        WIDX_DISABLE: strobe.rdSel = SEL_DISABLE;
        WIDX_CEADDR:  strobe.rdSel = SEL_CEADDR;
        WIDX_UEADDR:  strobe.rdSel = SEL_UEADDR;
        WIDX_IMPL:    strobe.rdSel = SEL_IMPL;
        WIDX_READY:   strobe.rdSel = SEL_READY;
        default:      strobe.rdSel = SEL_NONE;
      endcase
    end
  end

  AST_BAD_ACCESS_INERT: assert property (@(posedge clk) disable iff (!rstN)
    ((busAddr[1:0] != 2'b00) || (busByteEn != 4'hF)) |->
      (!strobe.statusClr && !strobe.maskEnable && !strobe.maskDisable &&
       !strobe.errCtlWr && strobe.rdSel == SEL_NONE)); // R12
endmodule

// File: rtl/irq_bank_datapath.sv
module irq_bank_datapath
  import irq_bank_pkg::*;
#(
  parameter logic [CODE_W-1:0] SIZE_CODE = 4'd4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  bankStrobe_t             strobe,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [IRQ_W-1:0]        eventIn,
  input  logic [FAULT_ADDR_W-1:0] ceFaultAddr,
  input  logic [FAULT_ADDR_W-1:0] ueFaultAddr,
  output logic [DATA_W-1:0]       rdata,
  output logic                    irqOut
);
  localparam logic [IRQ_W-1:0]   MASK_RESET   = '1;
  localparam logic [ERR_W-1:0]   ERR_RESET    = '1;
  localparam logic [READY_W-1:0] READY_VALUE  = '1;

  logic [IRQ_W-1:0] statusReg;
  logic [IRQ_W-1:0] maskReg;
  logic [ERR_W-1:0] errCtlReg;
  logic [IRQ_W-1:0] wBits;
  logic [IRQ_W-1:0] clrBits;

  assign wBits   = wdata[IRQ_W-1:0];
  assign clrBits = strobe.statusClr ? wBits : '0;

  // Status: event set wins over write-one-to-clear
  always_ff @(posedge clk) begin
    if (!rstN) statusReg <= '0;
    else       statusReg <= (statusReg & ~clrBits) | eventIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                   maskReg <= MASK_RESET;
    else if (strobe.maskEnable)  maskReg <= maskReg & ~wBits;
    else if (strobe.maskDisable) maskReg <= maskReg | wBits;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                errCtlReg <= ERR_RESET;
    else if (strobe.errCtlWr) errCtlReg <= wdata[ERR_W-1:0];
  end

  assign irqOut = |(statusReg & ~maskReg);

  always_comb begin
    rdata = '0;
    case (strobe.rdSel)
      SEL_ERRCTL: rdata = DATA_W'(errCtlReg);
      SEL_STATUS: rdata = DATA_W'(statusReg);
      SEL_MASK:   rdata = DATA_W'(maskReg);
      SEL_CEADDR: rdata = DATA_W'(ceFaultAddr);
      SEL_UEADDR: rdata = DATA_W'(ueFaultAddr);
      SEL_IMPL:   rdata = DATA_W'(SIZE_CODE);
      SEL_READY:  rdata = DATA_W'(READY_VALUE);
      default:    rdata = '0;
    endcase
  end

  AST_STATUS_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    (eventIn == '0) |=> ((statusReg & ~$past(statusReg)) == '0)); // R2
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (eventIn != '0) |=> ((statusReg & $past(eventIn)) == $past(eventIn))); // R4
  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.maskEnable && !strobe.maskDisable) |=> $stable(maskReg)); // R7
  AST_ENABLE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.maskEnable |=> ((maskReg & $past(wBits)) == '0)); // R5
  AST_DISABLE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.maskDisable |=> ((maskReg & $past(wBits)) == $past(wBits))); // R6
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (maskReg == MASK_RESET) |-> !irqOut); // R8
endmodule

// File: rtl/irq_bank_top.sv
module irq_bank_top
  import irq_bank_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter longint unsigned RAM_BYTES = 64'd1048576
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    busWrite,
  input  logic                    busRead,
  input  logic [ADDR_W-1:0]       busAddr,
  input  logic [3:0]              busByteEn,
  input  logic [DATA_W-1:0]       busWdata,
  input  logic [IRQ_W-1:0]        eventIn,
  input  logic [FAULT_ADDR_W-1:0] ceFaultAddr,
  input  logic [FAULT_ADDR_W-1:0] ueFaultAddr,
  output logic [DATA_W-1:0]       busRdata,
  output logic                    irqOut
);
  localparam logic [CODE_W-1:0] SIZE_CODE = sizeToCode(RAM_BYTES);

  generate
    if (SIZE_CODE == 4'hF) begin : g_badSize
      $error("irq_bank_top: RAM_BYTES must be 64K, 128K, 256K, 512K or 1M"); // R10
    end
  endgenerate

  bankStrobe_t strobe;

  irq_bank_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busWrite  (busWrite),
    .busRead   (busRead),
    .busAddr   (busAddr),
    .busByteEn (busByteEn),
    .strobe    (strobe)
  );

  irq_bank_datapath #(.SIZE_CODE(SIZE_CODE)) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .wdata       (busWdata),
    .eventIn     (eventIn),
    .ceFaultAddr (ceFaultAddr),
    .ueFaultAddr (ueFaultAddr),
    .rdata       (busRdata),
    .irqOut      (irqOut)
  );
endmodule

// File: tb/irq_bank_top_tb.sv
module irq_bank_top_tb;
  localparam int A_ERR = 8'h00, A_ST = 8'h04, A_MSK = 8'h08, A_EN = 8'h0C,
                 A_DIS = 8'h10, A_CE = 8'h14, A_UE = 8'h18, A_IMP = 8'h1C,
                 A_RDY = 8'h20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrite = 1'b0, busRead = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [3:0]  busByteEn = 4'hF;
  logic [31:0] busWdata = '0;
  logic [10:0] eventIn = '0;
  logic [19:0] ceFaultAddr = 20'hABCDE, ueFaultAddr = 20'h12345;
  logic [31:0] busRdata, smallRdata;
  logic        irqOut, smallIrq;

  int errors = 0, checks = 0;
  bit done = 1'b0;
  logic [10:0] mStatus = '0, mMask = 11'h7FF;
  logic [3:0]  mErr = 4'hF;

  always #5 clk = ~clk;

  irq_bank_top u_dut (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busRead(busRead),
    .busAddr(busAddr), .busByteEn(busByteEn), .busWdata(busWdata),
    .eventIn(eventIn), .ceFaultAddr(ceFaultAddr), .ueFaultAddr(ueFaultAddr),
    .busRdata(busRdata), .irqOut(irqOut));

  irq_bank_top #(.RAM_BYTES(64'd131072)) u_dut128 (
    .clk(clk), .rstN(rstN), .busWrite(1'b0), .busRead(busRead),
    .busAddr(busAddr), .busByteEn(busByteEn), .busWdata(busWdata),
    .eventIn(11'd0), .ceFaultAddr(ceFaultAddr), .ueFaultAddr(ueFaultAddr),
    .busRdata(smallRdata), .irqOut(smallIrq));

  function automatic logic expIrq(logic [10:0] s, logic [10:0] m);
    return |(s & ~m);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One bus cycle with optional event pulse; model updated after the edge
  task automatic cycle(bit wr, int addr, logic [31:0] data, logic [3:0] be,
                       logic [10:0] ev);
    @(negedge clk);
    busWrite = wr; busRead = 1'b0; busAddr = 8'(addr); busWdata = data;
    busByteEn = be; eventIn = ev;
    @(posedge clk);
    if (wr && be == 4'hF && addr[1:0] == 2'b00) begin
      case (addr)
        A_ST:  mStatus = mStatus & ~data[10:0];
        A_EN:  mMask = mMask & ~data[10:0];
        A_DIS: mMask = mMask | data[10:0];
        A_ERR: mErr = data[3:0];
        default: ;
      endcase
    end
    mStatus = mStatus | ev;
  endtask

  task automatic readCheck(string req, int addr, logic [3:0] be,
                           logic [31:0] exp);
    @(negedge clk);
    busWrite = 1'b0; busRead = 1'b1; busAddr = 8'(addr); busByteEn = be;
    eventIn = '0;
    #1;
    check(req, busRdata, exp);
    busRead = 1'b0; busByteEn = 4'hF;
  endtask

  task automatic irqCheck(string req);
    @(negedge clk);
    busWrite = 1'b0; busRead = 1'b0; eventIn = '0;
    #1;
    check(req, {31'd0, irqOut}, {31'd0, expIrq(mStatus, mMask)});
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    int seedVal;
    seedVal = $urandom(32'h5EED);
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1 reset state
    readCheck("R1 status", A_ST, 4'hF, 32'h0);
    readCheck("R1 mask", A_MSK, 4'hF, 32'h7FF);
    readCheck("R1 errctl", A_ERR, 4'hF, 32'hF);
    irqCheck("R1 irq");
    readCheck("R7 enable reads zero", A_EN, 4'hF, 32'h0);
    readCheck("R7 disable reads zero", A_DIS, 4'hF, 32'h0);
    readCheck("R11 ready", A_RDY, 4'hF, 32'hFFFF);
    readCheck("R10 impl 1MiB", A_IMP, 4'hF, 32'h4);
    @(negedge clk); busRead = 1'b1; busAddr = A_IMP; #1;
    check("R10 impl 128KiB", smallRdata, 32'h1); busRead = 1'b0;
    readCheck("R13 ce addr", A_CE, 4'hF, 32'h000ABCDE);
    readCheck("R13 ue addr", A_UE, 4'hF, 32'h00012345);

    // R2 event sets, masked irq stays low (R8)
    cycle(0, A_ST, 0, 4'hF, 11'h008);
    readCheck("R2 event sets", A_ST, 4'hF, 32'h8);
    irqCheck("R8 masked");
    cycle(1, A_EN, 32'h8, 4'hF, '0);
    readCheck("R5 enable clears", A_MSK, 4'hF, 32'h7F7);
    irqCheck("R8 unmasked");
    cycle(1, A_MSK, 32'h0, 4'hF, '0);
    readCheck("R7 mask write ignored", A_MSK, 4'hF, 32'h7F7);
    cycle(1, A_DIS, 32'h8, 4'hF, '0);
    readCheck("R6 disable sets", A_MSK, 4'hF, 32'h7FF);
    irqCheck("R8 remasked");

    // R4 collision, then R3 clear
    cycle(1, A_ST, 32'hFFFF_FFFF, 4'hF, 11'h020);
    readCheck("R4 set wins", A_ST, 4'hF, 32'h20);
    cycle(1, A_ST, 32'h20, 4'hF, '0);
    readCheck("R3 w1c", A_ST, 4'hF, 32'h0);

    // R9
    cycle(1, A_ERR, 32'hFFFF_FFF5, 4'hF, '0);
    readCheck("R9 errctl", A_ERR, 4'hF, 32'h5);

    // R12 bad accesses
    cycle(1, A_ERR + 1, 32'h0, 4'hF, '0);
    readCheck("R12 misaligned write", A_ERR, 4'hF, 32'h5);
    cycle(1, A_ERR, 32'h0, 4'h3, '0);
    readCheck("R12 partial write", A_ERR, 4'hF, 32'h5);
    readCheck("R12 partial read", A_ERR, 4'h1, 32'h0);
    readCheck("R12 misaligned read", A_RDY + 2, 4'hF, 32'h0);

    // R11, R10 read-only
    cycle(1, A_RDY, 32'h0, 4'hF, '0);
    readCheck("R11 ready ro", A_RDY, 4'hF, 32'hFFFF);
    cycle(1, A_IMP, 32'h0, 4'hF, '0);
    readCheck("R10 impl ro", A_IMP, 4'hF, 32'h4);

    // Random phase: R2 R3 R4 R5 R6 R8
    for (int i = 0; i < 400; i++) begin
      int op;
      logic [31:0] d;
      logic [10:0] ev;
      op = int'($urandom_range(0, 4));
      d  = $urandom();
      ev = ($urandom_range(0, 2) == 0) ? 11'($urandom()) : 11'd0;
      case (op)
        0: cycle(1, A_ST, d, 4'hF, ev);
        1: cycle(1, A_EN, d & 32'h0000_0111, 4'hF, ev);
        2: cycle(1, A_DIS, d, 4'hF, ev);
        3: cycle(1, A_ERR, d, 4'hF, ev);
        default: cycle(0, A_ST, d, 4'hF, ev);
      endcase
      if (i % 4 == 0) begin
        readCheck("R3 R4 random status", A_ST, 4'hF, {21'd0, mStatus});
        readCheck("R5 R6 random mask", A_MSK, 4'hF, {21'd0, mMask});
        readCheck("R9 random errctl", A_ERR, 4'hF, {28'd0, mErr});
      end
      irqCheck("R8 random irq");
    end
    summary();
  end
endmodule